// File: doc/BRIEF.md
# Frame Buffer Burst Request Controller

This block sits in the memory-controller clock domain, between a camera-side write FIFO, a display-side read FIFO and a simple burst port of an SDRAM command sequencer. It watches the fill levels of both FIFOs. When the camera FIFO has built up enough words, it asks the sequencer for a write burst. When the display FIFO is running low, it asks for a read burst. Each request carries a start address made of a frame-region (bank) index above a 20-bit word offset.

Write and read offsets are tracked independently. Each advances by one burst length when the sequencer reports that a burst has finished. When an offset reaches the end of a 640x480 frame, it wraps to zero and a one-cycle frame-done pulse is raised for that direction. A load strobe returns either offset to the region start, so that frame switching logic can re-align the two streams. While a burst runs, the sequencer's per-word beat strobe is steered to the pop side of the write FIFO or to the push side of the read FIFO.

Top module: `fb_burst_arbiter`

## Requirements
- R1: While `mem_ready` is low, `req_valid` never rises, whatever the FIFO levels are.
- R2: From idle with `mem_ready` high, a write request (`req_is_write`=1) is raised one cycle after a cycle in which `wr_level` >= 8.
- R3: From idle with `mem_ready` high, a read request (`req_is_write`=0) is raised one cycle after a cycle in which `rd_level` <= 8 and `wr_level` < 8.
- R4: When the write and read conditions hold in the same cycle, the write request is issued first.
- R5: `req_valid` stays high, with `req_addr` and `req_is_write` unchanged, until a cycle with `req_ack` high, and is low in the cycle after that. No new request is raised between the acknowledge and `burst_done`.
- R6: `req_addr` is the 2-bit bank index of the request's direction in bits 21:20, above the 20-bit word offset in bits 19:0. `req_len` is 256.
- R7: A `burst_done` ends the active burst, and from the next cycle the offset of that direction is 256 higher. The other direction's offset is unchanged.
- R8: `wr_load` or `rd_load` returns that direction's offset to 0 from the next cycle. When it coincides with `burst_done` of the same direction, the load wins and no frame-done pulse is raised.
- R9: When an advanced offset would reach 307200 or more, the offset becomes 0, and `frame_wr_done` or `frame_rd_done` is high for exactly the one cycle after the `burst_done`.
- R10: Between acknowledge and `burst_done`, `mem_beat` appears on `wfifo_rd_en` for a write burst or on `rfifo_wr_en` for a read burst. Outside a burst, neither strobe is driven.
- R11: After reset, `req_valid`, both frame-done outputs and both strobes are low, and both offsets are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory-domain clock |
| rst | input | 1 | Synchronous reset, active high |
| mem_ready | input | 1 | Memory initialisation finished |
| wr_level | input | 10 | Words held in the camera-side FIFO |
| rd_level | input | 10 | Words held in the display-side FIFO |
| wr_bank | input | 2 | Frame region for writes |
| rd_bank | input | 2 | Frame region for reads |
| wr_load | input | 1 | Reset write offset to region start |
| rd_load | input | 1 | Reset read offset to region start |
| req_valid | output | 1 | Burst request pending |
| req_is_write | output | 1 | 1 = write burst, 0 = read burst |
| req_addr | output | 22 | Burst start address {bank, offset} |
| req_len | output | 9 | Burst length in words |
| req_ack | input | 1 | Sequencer accepted the request |
| mem_beat | input | 1 | One data word moves this cycle |
| burst_done | input | 1 | Sequencer finished the burst |
| wfifo_rd_en | output | 1 | Pop strobe for the camera-side FIFO |
| rfifo_wr_en | output | 1 | Push strobe for the display-side FIFO |
| frame_wr_done | output | 1 | One-cycle pulse: a full frame written |
| frame_rd_done | output | 1 | One-cycle pulse: a full frame read |

## Verification
A request is due one clock after the edge that sees the qualifying levels in idle. It is gone one clock after the edge that sees `req_ack`. The offset advance and any frame-done pulse appear one clock after the edge that sees `burst_done`. The beat strobes follow `mem_beat` within the same cycle. The bench drives all inputs on falling edges and samples one falling edge after each causing rising edge, or a delay step after driving for the combinational strobes. A driver task queues the expected direction and address before the levels can trigger a request, and a falling-edge monitor pops the queue each time `req_valid` rises. Long runs of bursts carry both offsets across the frame end, to check the wrap and the single pulse.

// File: rtl/fb_arb_pkg.sv
package fb_arb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_BUSY = 2'd2
  } arb_state_t;

  localparam int unsigned DIR_WR = 0;
  localparam int unsigned DIR_RD = 1;
  localparam int unsigned NUM_DIR = 2;
endpackage

// File: rtl/fb_offset_track.sv
module fb_offset_track #(
  parameter int unsigned OFS_W       = 20,
  parameter int unsigned BURST_LEN   = 256,
  parameter int unsigned FRAME_WORDS = 307200
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             step,
  output logic [OFS_W-1:0] ofs,
  output logic             frame_done
);
  localparam int unsigned SUM_W = OFS_W + 1;

  logic [SUM_W-1:0] adv;
  logic             wraps;

  assign adv   = {1'b0, ofs} + SUM_W'(BURST_LEN);
  assign wraps = (adv >= SUM_W'(FRAME_WORDS));

  always_ff @(posedge clk) begin
    if (rst) begin
      ofs        <= '0;
      frame_done <= 1'b0;
    end else begin
      frame_done <= 1'b0;
      if (load) begin
        ofs <= '0;
      end else if (step) begin
        if (wraps) begin
          ofs        <= '0;
          frame_done <= 1'b1;
        end else begin
          ofs <= adv[OFS_W-1:0];
        end
      end
    end
  end
endmodule

// File: rtl/fb_req_fsm.sv
module fb_req_fsm
  import fb_arb_pkg::*;
#(
  parameter int unsigned ADDR_W = 22
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mem_ready,
  input  logic              wr_due,
  input  logic              rd_due,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              req_ack,
  input  logic              burst_done,
  output logic              req_valid,
  output logic              req_is_write,
  output logic [ADDR_W-1:0] req_addr,
  output logic              in_burst,
  output logic              step_wr,
  output logic              step_rd
);
  arb_state_t state;

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      req_valid    <= 1'b0;
      req_is_write <= 1'b0;
      req_addr     <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (mem_ready && (wr_due || rd_due)) begin
            req_valid    <= 1'b1;
            req_is_write <= wr_due;
            req_addr     <= wr_due ? wr_addr : rd_addr;
            state        <= ST_REQ;
          end
        end
        ST_REQ: begin
          if (req_ack) begin
            req_valid <= 1'b0;
            state     <= ST_BUSY;
          end
        end
        ST_BUSY: begin
          if (burst_done) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign in_burst = (state == ST_BUSY);
  assign step_wr  = in_burst && burst_done && req_is_write;
  assign step_rd  = in_burst && burst_done && !req_is_write;
endmodule

// File: rtl/fb_burst_arbiter.sv
module fb_burst_arbiter
  import fb_arb_pkg::*;
#(
  parameter int unsigned LEVEL_W     = 10,
  parameter int unsigned BANK_W      = 2,
  parameter int unsigned OFS_W       = 20,
  parameter int unsigned BURST_LEN   = 256,
  parameter int unsigned FRAME_WORDS = 307200,
  parameter int unsigned WR_THRESH   = 8,
  parameter int unsigned RD_THRESH   = 8,
  localparam int unsigned ADDR_W     = BANK_W + OFS_W,
  localparam int unsigned LEN_W      = $clog2(BURST_LEN + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               mem_ready,
  input  logic [LEVEL_W-1:0] wr_level,
  input  logic [LEVEL_W-1:0] rd_level,
  input  logic [BANK_W-1:0]  wr_bank,
  input  logic [BANK_W-1:0]  rd_bank,
  input  logic               wr_load,
  input  logic               rd_load,
  output logic               req_valid,
  output logic               req_is_write,
  output logic [ADDR_W-1:0]  req_addr,
  output logic [LEN_W-1:0]   req_len,
  input  logic               req_ack,
  input  logic               mem_beat,
  input  logic               burst_done,
  output logic               wfifo_rd_en,
  output logic               rfifo_wr_en,
  output logic               frame_wr_done,
  output logic               frame_rd_done
);
  logic [OFS_W-1:0] ofs   [NUM_DIR];
  logic             fdone [NUM_DIR];
  logic             load  [NUM_DIR];
  logic             step  [NUM_DIR];
  logic             in_burst;
  logic             wr_due, rd_due;

  assign load[DIR_WR] = wr_load;
  assign load[DIR_RD] = rd_load;

  generate
    for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
      fb_offset_track #(
        .OFS_W      (OFS_W),
        .BURST_LEN  (BURST_LEN),
        .FRAME_WORDS(FRAME_WORDS)
      ) u_track (
        .clk       (clk),
        .rst       (rst),
        .load      (load[d]),
        .step      (step[d]),
        .ofs       (ofs[d]),
        .frame_done(fdone[d])
      );
    end
  endgenerate

  assign wr_due = (wr_level >= LEVEL_W'(WR_THRESH));
  assign rd_due = (rd_level <= LEVEL_W'(RD_THRESH));

  fb_req_fsm #(
    .ADDR_W(ADDR_W)
  ) u_fsm (
    .clk         (clk),
    .rst         (rst),
    .mem_ready   (mem_ready),
    .wr_due      (wr_due),
    .rd_due      (rd_due),
    .wr_addr     ({wr_bank, ofs[DIR_WR]}),
    .rd_addr     ({rd_bank, ofs[DIR_RD]}),
    .req_ack     (req_ack),
    .burst_done  (burst_done),
    .req_valid   (req_valid),
    .req_is_write(req_is_write),
    .req_addr    (req_addr),
    .in_burst    (in_burst),
    .step_wr     (step[DIR_WR]),
    .step_rd     (step[DIR_RD])
  );

  assign req_len       = LEN_W'(BURST_LEN);
  assign wfifo_rd_en   = mem_beat && in_burst && req_is_write;
  assign rfifo_wr_en   = mem_beat && in_burst && !req_is_write;
  assign frame_wr_done = fdone[DIR_WR];
  assign frame_rd_done = fdone[DIR_RD];
endmodule

// File: rtl/fb_burst_arbiter_chk.sv
module fb_burst_arbiter_chk #(
  parameter int unsigned LEVEL_W   = 10,
  parameter int unsigned ADDR_W    = 22,
  parameter int unsigned WR_THRESH = 8,
  parameter int unsigned RD_THRESH = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               mem_ready,
  input logic [LEVEL_W-1:0] wr_level,
  input logic [LEVEL_W-1:0] rd_level,
  input logic               req_valid,
  input logic               req_is_write,
  input logic [ADDR_W-1:0]  req_addr,
  input logic               req_ack,
  input logic               burst_done,
  input logic               wfifo_rd_en,
  input logic               rfifo_wr_en,
  input logic               frame_wr_done,
  input logic               frame_rd_done
);
  // Burst window rebuilt from the handshake ports alone
  logic c_busy;
  always_ff @(posedge clk) begin
    if (rst)                       c_busy <= 1'b0;
    else if (req_valid && req_ack) c_busy <= 1'b1;
    else if (burst_done)           c_busy <= 1'b0;
  end

  a_r1_ready_gate: assert property (@(posedge clk) disable iff (rst)
    $rose(req_valid) |-> $past(mem_ready));

  a_r2_write_level: assert property (@(posedge clk) disable iff (rst)
    ($rose(req_valid) && req_is_write) |-> $past(wr_level >= LEVEL_W'(WR_THRESH)));

  a_r3_read_level: assert property (@(posedge clk) disable iff (rst)
    ($rose(req_valid) && !req_is_write) |->
      ($past(rd_level <= LEVEL_W'(RD_THRESH)) && $past(wr_level < LEVEL_W'(WR_THRESH))));

  a_r4_write_first: assert property (@(posedge clk) disable iff (rst)
    ($rose(req_valid) && $past(wr_level >= LEVEL_W'(WR_THRESH))) |-> req_is_write);

  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ack) |=> (req_valid && $stable(req_addr) && $stable(req_is_write)));

  a_r5_drop: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ack) |=> !req_valid);

  a_r5_quiet_in_burst: assert property (@(posedge clk) disable iff (rst)
    c_busy |-> !req_valid);

  a_r9_wr_pulse_single: assert property (@(posedge clk) disable iff (rst)
    frame_wr_done |=> !frame_wr_done);

  a_r9_rd_pulse_single: assert property (@(posedge clk) disable iff (rst)
    frame_rd_done |=> !frame_rd_done);

  a_r10_no_beat_idle: assert property (@(posedge clk) disable iff (rst)
    !c_busy |-> (!wfifo_rd_en && !rfifo_wr_en));

  a_r10_one_strobe: assert property (@(posedge clk) disable iff (rst)
    $onehot0({wfifo_rd_en, rfifo_wr_en}));
endmodule

bind fb_burst_arbiter fb_burst_arbiter_chk #(
  .LEVEL_W  (LEVEL_W),
  .ADDR_W   (ADDR_W),
  .WR_THRESH(WR_THRESH),
  .RD_THRESH(RD_THRESH)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .mem_ready    (mem_ready),
  .wr_level     (wr_level),
  .rd_level     (rd_level),
  .req_valid    (req_valid),
  .req_is_write (req_is_write),
  .req_addr     (req_addr),
  .req_ack      (req_ack),
  .burst_done   (burst_done),
  .wfifo_rd_en  (wfifo_rd_en),
  .rfifo_wr_en  (rfifo_wr_en),
  .frame_wr_done(frame_wr_done),
  .frame_rd_done(frame_rd_done)
);

// File: tb/fb_burst_arbiter_tb.sv
module fb_burst_arbiter_tb;
  localparam int CLK_PERIOD = 10;
  localparam int BLEN   = 256;
  localparam int FRAME  = 307200;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mem_ready = 1'b0;
  logic [9:0]  wr_level = '0;
  logic [9:0]  rd_level = 10'd100;
  logic [1:0]  wr_bank = 2'd1;
  logic [1:0]  rd_bank = 2'd3;
  logic        wr_load = 1'b0, rd_load = 1'b0;
  logic        req_valid, req_is_write;
  logic [21:0] req_addr;
  logic [8:0]  req_len;
  logic        req_ack = 1'b0, mem_beat = 1'b0, burst_done = 1'b0;
  logic        wfifo_rd_en, rfifo_wr_en, frame_wr_done, frame_rd_done;

  int n_checks = 0;
  int n_fail   = 0;
  int wofs = 0, rofs = 0;
  int wraps_seen;
  bit summary_done = 0;
  logic [22:0] exp_q [$];
  logic        prev_req = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fb_burst_arbiter u_dut (
    .clk(clk), .rst(rst), .mem_ready(mem_ready),
    .wr_level(wr_level), .rd_level(rd_level),
    .wr_bank(wr_bank), .rd_bank(rd_bank),
    .wr_load(wr_load), .rd_load(rd_load),
    .req_valid(req_valid), .req_is_write(req_is_write),
    .req_addr(req_addr), .req_len(req_len),
    .req_ack(req_ack), .mem_beat(mem_beat), .burst_done(burst_done),
    .wfifo_rd_en(wfifo_rd_en), .rfifo_wr_en(rfifo_wr_en),
    .frame_wr_done(frame_wr_done), .frame_rd_done(frame_rd_done)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Monitor: every new request is compared with the next queued expectation (R2 R3 R4 R6)
  always @(negedge clk) begin
    if (!rst && req_valid && !prev_req) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R1/R5 unexpected request", {req_is_write, req_addr}, 0);
      end else begin
        logic [22:0] e;
        e = exp_q.pop_front();
        check({req_is_write, req_addr} == e, "R6 request dir/addr", {req_is_write, req_addr}, e);
      end
    end
    prev_req = rst ? 1'b0 : req_valid;
  end

  // Driver: queue expectation, serve one burst, then check offset step and frame pulse
  task automatic run_burst(input bit w, input int ack_dly, input int busy_dly, input bit load_at_done);
    int t = 0;
    bit fd = 0;
    int nxt;
    exp_q.push_back({w, w ? (22'(wr_bank) << 20) | 22'(wofs) : (22'(rd_bank) << 20) | 22'(rofs)});
    while (!req_valid && t < 50) begin
      @(negedge clk);
      t++;
    end
    check(req_valid, "R2 R3 request raised", req_valid, 1);
    for (int i = 0; i < ack_dly; i++) begin
      @(negedge clk);
      check(req_valid, "R5 request held", req_valid, 1);
    end
    req_ack = 1'b1;
    @(negedge clk);
    req_ack = 1'b0;
    check(!req_valid, "R5 request dropped after ack", req_valid, 0);
    for (int i = 0; i < busy_dly; i++) begin
      mem_beat = 1'b1;
      #1;
      check(wfifo_rd_en == w && rfifo_wr_en == !w, "R10 beat steering",
            {wfifo_rd_en, rfifo_wr_en}, {w, !w});
      @(negedge clk);
      mem_beat = 1'b0;
      check(!req_valid, "R5 quiet during burst", req_valid, 0);
    end
    burst_done = 1'b1;
    if (load_at_done) begin
      if (w) wr_load = 1'b1; else rd_load = 1'b1;
    end
    @(negedge clk);
    burst_done = 1'b0;
    wr_load = 1'b0;
    rd_load = 1'b0;
    if (load_at_done) begin
      if (w) wofs = 0; else rofs = 0;
    end else begin
      nxt = (w ? wofs : rofs) + BLEN;
      if (nxt >= FRAME) begin
        nxt = 0;
        fd = 1;
      end
      if (w) wofs = nxt; else rofs = nxt;
    end
    if (fd) wraps_seen++;
    check(frame_wr_done == (w && fd) && frame_rd_done == (!w && fd), "R9 frame pulse",
          {frame_wr_done, frame_rd_done}, {w && fd, !w && fd});
    if (fd) begin
      @(negedge clk);
      check(!frame_wr_done && !frame_rd_done, "R9 pulse one cycle",
            {frame_wr_done, frame_rd_done}, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    if (!summary_done) $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R11: reset state
    check(!req_valid && !frame_wr_done && !frame_rd_done, "R11 reset outputs",
          {req_valid, frame_wr_done, frame_rd_done}, 0);
    mem_beat = 1'b1;
    #1;
    check(!wfifo_rd_en && !rfifo_wr_en, "R11 R10 no strobe after reset",
          {wfifo_rd_en, rfifo_wr_en}, 0);
    mem_beat = 1'b0;
    check(req_len == 9'd256, "R6 burst length", req_len, 256);

    // R1: levels qualify but memory not ready
    wr_level = 10'd20;
    rd_level = 10'd0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      check(!req_valid, "R1 gated before ready", req_valid, 0);
    end

    // R4: both due, write first (R2 at the exact threshold 8)
    @(negedge clk);
    mem_ready = 1'b1;
    wr_level = 10'd8;
    rd_level = 10'd8;
    run_burst(1'b1, 2, 3, 1'b0);

    // R3: read at threshold 8 with write below threshold
    wr_level = 10'd7;
    run_burst(1'b0, 0, 2, 1'b0);

    // Neither due: 7 words to write, 9 in read FIFO
    rd_level = 10'd9;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      check(!req_valid, "R2 R3 no request below thresholds", req_valid, 0);
    end

    // R7: independent offset advance
    wr_level = 10'd300;
    run_burst(1'b1, 1, 1, 1'b0);
    run_burst(1'b1, 0, 1, 1'b0);
    wr_level = 10'd0;
    rd_level = 10'd3;
    run_burst(1'b0, 3, 1, 1'b0);

    // R8: load while idle, read offset untouched
    rd_level = 10'd100;
    @(negedge clk);
    wr_load = 1'b1;
    @(negedge clk);
    wr_load = 1'b0;
    wofs = 0;
    wr_bank = 2'd2;
    wr_level = 10'd50;
    run_burst(1'b1, 0, 1, 1'b0);
    wr_level = 10'd0;
    rd_level = 10'd0;
    run_burst(1'b0, 0, 1, 1'b0);

    // R8: load coinciding with done wins
    run_burst(1'b0, 0, 1, 1'b1);
    run_burst(1'b0, 0, 1, 1'b0);

    // R9: write stream across the frame end
    wr_level = 10'd500;
    rd_level = 10'd200;
    wraps_seen = 0;
    for (int i = 0; i < 1300 && wraps_seen == 0; i++) run_burst(1'b1, 0, 1, 1'b0);
    check(wraps_seen == 1, "R9 write wrap reached", wraps_seen, 1);
    run_burst(1'b1, 0, 1, 1'b0);

    // R9: read stream across the frame end
    wr_level = 10'd0;
    rd_level = 10'd1;
    wraps_seen = 0;
    for (int i = 0; i < 1300 && wraps_seen == 0; i++) run_burst(1'b0, 0, 1, 1'b0);
    check(wraps_seen == 1, "R9 read wrap reached", wraps_seen, 1);
    run_burst(1'b0, 1, 1, 1'b0);

    rd_level = 10'd100;
    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R5 all expected requests seen", exp_q.size(), 0);
    summary_done = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule